// File: doc/BRIEF.md
# PCI Slot Hotplug Event Controller

This block tells system firmware that a PCI slot has gained or lost a device. A sideband event port delivers a slot number and an event kind. For a hot-add or a hot-remove, the block rewrites two 32-bit slot bitmaps, one for arrivals and one for departures. It also sets the hotplug bit of a small general-purpose event (GPE) register block. When that bit is enabled, the block drives a level interrupt. A device that is present at machine build is reported with the cold kind, and it leaves every register alone.

Firmware uses a word-wide register window to read the bitmaps and the mask of removable slots, and to request an eject. To request an eject, firmware writes a word whose lowest set bit names the slot. If that slot is removable, the block emits a one-cycle eject strobe carrying the slot number. The GPE block is a separate byte-wide window. Its status bytes are cleared by writing 1. Its enable bytes are plain read/write.

Top module: `slot_hp_evt_ctrl`

## Requirements
- R1: The word window decodes `hp_addr[3:2]` as byte offsets 0x0 = up bitmap, 0x4 = down bitmap, 0x8 = eject, 0xC = removable mask. `hp_rdata` follows the address combinationally. After reset both bitmaps, all four GPE bytes and `sci_irq` are zero.
- R2: Writes to offsets 0x0 and 0x4 leave both bitmaps unchanged.
- R3: A hot-add event (`evt_kind` 2'b01) first clears both bitmaps and then sets bit `evt_slot` of the up bitmap. A hot-remove event (2'b10) does the same, setting the bit in the down bitmap. Either result is visible after the clock edge that samples `evt_valid`.
- R4: Every hot-add or hot-remove event sets bit 1 of GPE status byte 0.
- R5: `sci_irq` is high exactly when bit 1 of GPE status byte 0 and bit 1 of GPE enable byte 0 are both set.
- R6: A cold-plug event (2'b00) and the reserved kind (2'b11) change no bitmap and no GPE byte.
- R7: A write to offset 0x8 selects the slot given by the lowest set bit of the written word. If that slot's removable bit is set, `eject_stb` is high for exactly the following cycle with `eject_slot` equal to that slot. A zero word, or a slot that is not removable, gives no strobe.
- R8: Offset 0x8 reads as zero.
- R9: The removable mask is `hp_cap` sampled at the first clock edge after reset is released. Until that edge it follows `hp_cap`. Later changes of `hp_cap` and writes to offset 0xC do not alter it until the next reset.
- R10: GPE byte addresses 0 and 1 are status bytes, where writing 1 to a bit clears it and writing 0 leaves it unchanged. Addresses 2 and 3 are the enable bytes for status bytes 0 and 1, and they are read/write. `gpe_rdata` shows the addressed byte combinationally.
- R11: A hot event in the same cycle as a write that clears status byte 0 bit 1 leaves that bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hp_wr | input | 1 | Write strobe for the word window |
| hp_addr | input | 2 | Word select, byte offset bits [3:2] |
| hp_wdata | input | 32 | Write data for the word window |
| hp_rdata | output | 32 | Read data for the word window |
| gpe_wr | input | 1 | Write strobe for the GPE byte window |
| gpe_addr | input | 2 | GPE byte address |
| gpe_wdata | input | 8 | GPE write data |
| gpe_rdata | output | 8 | GPE read data |
| evt_valid | input | 1 | Hotplug notification valid |
| evt_slot | input | 5 | Slot number of the notification |
| evt_kind | input | 2 | 00 cold, 01 add, 10 remove, 11 reserved |
| hp_cap | input | 32 | Per-slot hotplug capability mask |
| sci_irq | output | 1 | Level interrupt request |
| eject_stb | output | 1 | One-cycle eject request |
| eject_slot | output | 5 | Slot to eject, valid with `eject_stb` |

## Verification
The bench builds the block with its default parameters: 32 slots, a 4-byte GPE block and hotplug bit 1. With these values every slot index from 0 to 31 can be reached, including bit 31 of the bitmaps. Both status bytes and both enable bytes are reachable as well. The capability masks used leave slots 2 and 7 non-removable, so the refused-eject path and the lowest-set-bit selection meet in single writes.

// File: rtl/hp_evt_pkg.sv
package hp_evt_pkg;
  typedef enum logic [1:0] {
    HP_EVT_COLD   = 2'b00,
    HP_EVT_ADD    = 2'b01,
    HP_EVT_REMOVE = 2'b10,
    HP_EVT_RSVD   = 2'b11
  } hp_evt_kind_e;

  localparam logic [1:0] HP_WORD_UP    = 2'd0;
  localparam logic [1:0] HP_WORD_DOWN  = 2'd1;
  localparam logic [1:0] HP_WORD_EJECT = 2'd2;
  localparam logic [1:0] HP_WORD_RMV   = 2'd3;
endpackage

// File: rtl/hp_slot_status.sv
module hp_slot_status
  import hp_evt_pkg::*;
#(
  parameter int SLOT_CNT = 32,
  parameter int SLOT_W   = $clog2(SLOT_CNT)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                evt_valid,
  input  logic [SLOT_W-1:0]   evt_slot,
  input  logic [1:0]          evt_kind,
  output logic [SLOT_CNT-1:0] up_map,
  output logic [SLOT_CNT-1:0] down_map,
  output logic                hot_evt
);
  hp_evt_kind_e        kind;
  logic [SLOT_CNT-1:0] up_d, down_d;

  assign kind    = hp_evt_kind_e'(evt_kind);
  assign hot_evt = evt_valid && (kind == HP_EVT_ADD || kind == HP_EVT_REMOVE);

  // both maps start from zero on every hot event
  always_comb begin
    up_d   = '0;
    down_d = '0;
    if (kind == HP_EVT_ADD) up_d[evt_slot]   = 1'b1;
    else                    down_d[evt_slot] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_map   <= '0;
      down_map <= '0;
    end else if (hot_evt) begin
      up_map   <= up_d;
      down_map <= down_d;
    end
  end
endmodule

// File: rtl/hp_gpe_block.sv
module hp_gpe_block #(
  parameter int GPE_LEN = 4,
  parameter int HP_BIT  = 1,
  parameter int AW      = $clog2(GPE_LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  input  logic          set_hp,
  output logic [7:0]    rdata,
  output logic          hp_sts,
  output logic          irq
);
  localparam int HALF = GPE_LEN / 2;
  localparam int IW   = AW - 1;

  logic [HALF-1:0][7:0] sts_q, sts_d;
  logic [HALF-1:0][7:0] en_q, en_d;
  logic                 sts_ce, en_ce;
  logic [IW-1:0]        idx;

  assign sts_ce = wr | set_hp;
  assign en_ce  = wr;

  always_comb begin
    sts_d = sts_q;
    en_d  = en_q;
    for (int i = 0; i < HALF; i++) begin
      if (wr && addr == AW'(i))        sts_d[i] = sts_q[i] & ~wdata;
      if (wr && addr == AW'(HALF + i)) en_d[i]  = wdata;
    end
    // a new event outranks a same-cycle clear
    if (set_hp) sts_d[0][HP_BIT] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sts_q <= '0;
    else if (sts_ce) sts_q <= sts_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_ce) en_q <= en_d;
  end

  assign idx    = addr[IW-1:0];
  assign rdata  = addr[AW-1] ? en_q[idx] : sts_q[idx];
  assign hp_sts = sts_q[0][HP_BIT];
  assign irq    = sts_q[0][HP_BIT] & en_q[0][HP_BIT];
endmodule

// File: rtl/hp_eject_dec.sv
module hp_eject_dec #(
  parameter int SLOT_CNT = 32,
  parameter int SLOT_W   = $clog2(SLOT_CNT)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr,
  input  logic [SLOT_CNT-1:0] wdata,
  input  logic [SLOT_CNT-1:0] removable,
  output logic                eject_stb,
  output logic [SLOT_W-1:0]   eject_slot
);
  logic [SLOT_W-1:0] low_idx;
  logic              fire;

  // descending scan so the lowest set bit is the last one written
  always_comb begin
    low_idx = '0;
    for (int i = SLOT_CNT - 1; i >= 0; i--) begin
      if (wdata[i]) low_idx = SLOT_W'(i);
    end
  end

  assign fire = wr && (|wdata) && removable[low_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) eject_stb <= 1'b0;
    else        eject_stb <= fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    eject_slot <= '0;
    else if (fire) eject_slot <= low_idx;
  end
endmodule

// File: rtl/slot_hp_evt_ctrl.sv
module slot_hp_evt_ctrl
  import hp_evt_pkg::*;
#(
  parameter int SLOT_CNT = 32,
  parameter int SLOT_W   = $clog2(SLOT_CNT),
  parameter int GPE_LEN  = 4,
  parameter int GPE_AW   = $clog2(GPE_LEN),
  parameter int HP_BIT   = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hp_wr,
  input  logic [3:2]          hp_addr,
  input  logic [SLOT_CNT-1:0] hp_wdata,
  output logic [SLOT_CNT-1:0] hp_rdata,
  input  logic                gpe_wr,
  input  logic [GPE_AW-1:0]   gpe_addr,
  input  logic [7:0]          gpe_wdata,
  output logic [7:0]          gpe_rdata,
  input  logic                evt_valid,
  input  logic [SLOT_W-1:0]   evt_slot,
  input  logic [1:0]          evt_kind,
  input  logic [SLOT_CNT-1:0] hp_cap,
  output logic                sci_irq,
  output logic                eject_stb,
  output logic [SLOT_W-1:0]   eject_slot
);
  logic [SLOT_CNT-1:0] up_map, down_map;
  logic                hot_evt, hp_sts;
  logic [SLOT_CNT-1:0] rmv_q, rmv_d, rmv_val;
  logic                snap_pend_q, snap_pend_d;
  logic                eject_wr;

  hp_slot_status #(.SLOT_CNT(SLOT_CNT), .SLOT_W(SLOT_W)) u_status (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_slot(evt_slot),
    .evt_kind(evt_kind), .up_map(up_map), .down_map(down_map), .hot_evt(hot_evt)
  );

  hp_gpe_block #(.GPE_LEN(GPE_LEN), .HP_BIT(HP_BIT), .AW(GPE_AW)) u_gpe (
    .clk(clk), .rst_n(rst_n), .wr(gpe_wr), .addr(gpe_addr), .wdata(gpe_wdata),
    .set_hp(hot_evt), .rdata(gpe_rdata), .hp_sts(hp_sts), .irq(sci_irq)
  );

  // removable mask: capability sampled once after reset
  always_comb begin
    snap_pend_d = 1'b0;
    rmv_d       = hp_cap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_pend_q <= 1'b1;
      rmv_q       <= '1;
    end else if (snap_pend_q) begin
      snap_pend_q <= snap_pend_d;
      rmv_q       <= rmv_d;
    end
  end

  assign rmv_val  = snap_pend_q ? hp_cap : rmv_q;
  assign eject_wr = hp_wr && (hp_addr == HP_WORD_EJECT);

  hp_eject_dec #(.SLOT_CNT(SLOT_CNT), .SLOT_W(SLOT_W)) u_eject (
    .clk(clk), .rst_n(rst_n), .wr(eject_wr), .wdata(hp_wdata),
    .removable(rmv_val), .eject_stb(eject_stb), .eject_slot(eject_slot)
  );

  always_comb begin
    unique case (hp_addr)
      HP_WORD_UP:    hp_rdata = up_map;
      HP_WORD_DOWN:  hp_rdata = down_map;
      HP_WORD_EJECT: hp_rdata = '0;
      default:       hp_rdata = rmv_val;
    endcase
  end
endmodule

// File: rtl/hp_evt_chk.sv
module hp_evt_chk #(
  parameter int SLOT_CNT = 32,
  parameter int SLOT_W   = $clog2(SLOT_CNT),
  parameter int GPE_AW   = 2,
  parameter int HP_BIT   = 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                hp_wr,
  input logic [3:2]          hp_addr,
  input logic [SLOT_CNT-1:0] hp_wdata,
  input logic                gpe_wr,
  input logic [GPE_AW-1:0]   gpe_addr,
  input logic [7:0]          gpe_wdata,
  input logic                evt_valid,
  input logic [SLOT_W-1:0]   evt_slot,
  input logic [1:0]          evt_kind,
  input logic [SLOT_CNT-1:0] up_map,
  input logic [SLOT_CNT-1:0] down_map,
  input logic                hp_sts,
  input logic                eject_stb,
  input logic [SLOT_W-1:0]   eject_slot,
  input logic [SLOT_CNT-1:0] rmv_val
);
  logic hot;
  assign hot = evt_valid && (evt_kind == 2'b01 || evt_kind == 2'b10);

  a_r3_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({up_map, down_map}) <= 1);

  a_r3_add: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid && evt_kind == 2'b01 |=>
      up_map == (SLOT_CNT'(1) << $past(evt_slot)) && down_map == '0);

  a_r3_remove: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid && evt_kind == 2'b10 |=>
      down_map == (SLOT_CNT'(1) << $past(evt_slot)) && up_map == '0);

  a_r4_sts_set: assert property (@(posedge clk) disable iff (!rst_n)
    hot |=> hp_sts);

  a_r11_evt_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    hot && gpe_wr && gpe_addr == '0 && gpe_wdata[HP_BIT] |=> hp_sts);

  a_r6_cold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid && !hot |=> $stable(up_map) && $stable(down_map) && !$rose(hp_sts));

  a_r2_maps_ro: assert property (@(posedge clk) disable iff (!rst_n)
    hp_wr && hp_addr[3] == 1'b0 && !hot |=> $stable(up_map) && $stable(down_map));

  a_r7_strobe_origin: assert property (@(posedge clk) disable iff (!rst_n)
    eject_stb |-> $past(hp_wr && hp_addr == 2'b10 && hp_wdata != '0));

  a_r7_removable_only: assert property (@(posedge clk) disable iff (!rst_n)
    eject_stb |-> rmv_val[eject_slot]);
endmodule

bind slot_hp_evt_ctrl hp_evt_chk #(
  .SLOT_CNT(SLOT_CNT), .SLOT_W(SLOT_W), .GPE_AW(GPE_AW), .HP_BIT(HP_BIT)
) u_chk (.*);

// File: tb/slot_hp_evt_ctrl_tb.sv
`timescale 1ns/1ps
module slot_hp_evt_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        hp_wr;
  logic [1:0]  hp_addr;
  logic [31:0] hp_wdata, hp_rdata;
  logic        gpe_wr;
  logic [1:0]  gpe_addr;
  logic [7:0]  gpe_wdata, gpe_rdata;
  logic        evt_valid;
  logic [4:0]  evt_slot;
  logic [1:0]  evt_kind;
  logic [31:0] hp_cap;
  logic        sci_irq, eject_stb;
  logic [4:0]  eject_slot;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [31:0]      m_up, m_down, m_rmv;
  logic [1:0][7:0]  m_sts, m_en;

  localparam logic [31:0] CAP_A = 32'hFFFF_FF7B; // slots 2, 7 fixed
  localparam logic [31:0] CAP_B = 32'h0F0F_F0F0;

  always #10 clk = ~clk;

  slot_hp_evt_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .hp_wr(hp_wr), .hp_addr(hp_addr),
    .hp_wdata(hp_wdata), .hp_rdata(hp_rdata), .gpe_wr(gpe_wr),
    .gpe_addr(gpe_addr), .gpe_wdata(gpe_wdata), .gpe_rdata(gpe_rdata),
    .evt_valid(evt_valid), .evt_slot(evt_slot), .evt_kind(evt_kind),
    .hp_cap(hp_cap), .sci_irq(sci_irq), .eject_stb(eject_stb),
    .eject_slot(eject_slot)
  );

  function automatic int low_bit(input logic [31:0] w);
    for (int i = 0; i < 32; i++) if (w[i]) return i;
    return -1;
  endfunction

  function automatic bit exp_irq();
    return m_sts[0][1] & m_en[0][1];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    hp_wr = 0; hp_addr = 0; hp_wdata = 0;
    gpe_wr = 0; gpe_addr = 0; gpe_wdata = 0;
    evt_valid = 0; evt_slot = 0; evt_kind = 0;
  endtask

  // called just after a negedge; stays within the low half period
  task automatic verify_all();
    hp_addr = 2'd0; #1 check("R1 R3 up map", hp_rdata, m_up);
    hp_addr = 2'd1; #1 check("R1 R3 down map", hp_rdata, m_down);
    hp_addr = 2'd2; #1 check("R8 eject reads zero", hp_rdata, 32'h0);
    hp_addr = 2'd3; #1 check("R9 removable", hp_rdata, m_rmv);
    for (int a = 0; a < 4; a++) begin
      gpe_addr = 2'(a); #1;
      check("R10 gpe byte", {24'h0, gpe_rdata}, {24'h0, a < 2 ? m_sts[a] : m_en[a-2]});
    end
    check("R5 irq", {31'h0, sci_irq}, {31'h0, exp_irq()});
    hp_addr = 0; gpe_addr = 0;
  endtask

  task automatic do_op(input bit ev, input logic [1:0] kind, input logic [4:0] slot,
                       input bit hw, input logic [1:0] ha, input logic [31:0] hd,
                       input bit gw, input logic [1:0] ga, input logic [7:0] gd);
    int lb;
    bit exp_stb;
    @(negedge clk);
    evt_valid = ev; evt_kind = kind; evt_slot = slot;
    hp_wr = hw; hp_addr = ha; hp_wdata = hd;
    gpe_wr = gw; gpe_addr = ga; gpe_wdata = gd;
    lb = low_bit(hd);
    exp_stb = hw && ha == 2'd2 && lb >= 0 && m_rmv[lb];
    @(posedge clk); #1;
    check("R7 eject strobe", {31'h0, eject_stb}, {31'h0, exp_stb});
    if (exp_stb) check("R7 eject slot", {27'h0, eject_slot}, lb);
    if (gw) begin
      if (ga < 2) m_sts[ga] = m_sts[ga] & ~gd;
      else        m_en[ga-2] = gd;
    end
    if (ev && (kind == 2'b01 || kind == 2'b10)) begin
      m_up = 0; m_down = 0;
      if (kind == 2'b01) m_up[slot] = 1'b1; else m_down[slot] = 1'b1;
      m_sts[0][1] = 1'b1;
    end
    @(negedge clk);
    idle();
    verify_all();
  endtask

  task automatic apply_reset(input logic [31:0] cap);
    @(negedge clk);
    rst_n = 0; hp_cap = cap; idle();
    m_up = 0; m_down = 0; m_sts = 0; m_en = 0; m_rmv = cap;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd4242);
    rst_n = 0; hp_cap = CAP_A; idle();
    apply_reset(CAP_A);
    verify_all(); // R1 reset state

    // R9: later capability changes and writes to 0xC are ignored
    hp_cap = CAP_B;
    do_op(0, 0, 0, 1, 2'd3, 32'h0000_0000, 0, 0, 0);
    check("R9 frozen mask", m_rmv, CAP_A);

    do_op(1, 2'b01, 5'd5, 0, 0, 0, 0, 0, 0);             // R3 add
    do_op(0, 0, 0, 0, 0, 0, 1, 2'd2, 8'h02);              // R5 enable
    do_op(1, 2'b10, 5'd31, 0, 0, 0, 0, 0, 0);            // R3 remove top slot
    do_op(1, 2'b01, 5'd0, 0, 0, 0, 0, 0, 0);             // R3 slot 0
    do_op(1, 2'b00, 5'd3, 0, 0, 0, 0, 0, 0);             // R6 cold
    do_op(1, 2'b11, 5'd9, 0, 0, 0, 0, 0, 0);             // R6 reserved
    do_op(0, 0, 0, 1, 2'd0, 32'hFFFF_FFFF, 0, 0, 0);     // R2 up write
    do_op(0, 0, 0, 1, 2'd1, 32'h1234_5678, 0, 0, 0);     // R2 down write
    do_op(0, 0, 0, 0, 0, 0, 1, 2'd0, 8'h02);              // R10 W1C, R5 irq drop
    do_op(0, 0, 0, 0, 0, 0, 1, 2'd1, 8'hFF);              // R10 status byte 1
    do_op(0, 0, 0, 0, 0, 0, 1, 2'd3, 8'hA5);              // R10 enable byte 1
    do_op(1, 2'b10, 5'd12, 0, 0, 0, 1, 2'd0, 8'h02);     // R11 event wins
    do_op(0, 0, 0, 1, 2'd2, 32'h0, 0, 0, 0);              // R7 zero word
    do_op(0, 0, 0, 1, 2'd2, 32'h0000_0084, 0, 0, 0);     // R7 slot 2 fixed
    do_op(0, 0, 0, 1, 2'd2, 32'h0000_0080, 0, 0, 0);     // R7 slot 7 fixed
    do_op(0, 0, 0, 1, 2'd2, 32'h8000_0110, 0, 0, 0);     // R7 slot 4
    do_op(0, 0, 0, 1, 2'd2, 32'h8000_0000, 0, 0, 0);     // R7 slot 31

    for (int n = 0; n < 400; n++) begin
      int sel;
      logic [31:0] w;
      sel = $urandom_range(0, 3);
      w = $urandom();
      if ($urandom_range(0, 1) == 1) w = w & (w << 3);
      do_op(sel != 1, 2'($urandom_range(0, 3)), 5'($urandom_range(0, 31)),
            $urandom_range(0, 1) == 1, 2'($urandom_range(0, 3)), w,
            $urandom_range(0, 1) == 1, 2'($urandom_range(0, 3)), 8'($urandom()));
    end

    apply_reset(CAP_B); // R9 recomputed on reset
    verify_all();
    do_op(0, 0, 0, 1, 2'd2, 32'h0000_0002, 0, 0, 0);     // R7 slot 1 fixed now
    do_op(0, 0, 0, 1, 2'd2, 32'h0000_0010, 0, 0, 0);     // R7 slot 4

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule